// File: doc/BRIEF.md
# Reset-Cause Status Flags

This block holds the status-register flags that tell firmware why the controller last restarted. A restart can come from four places: power-up, the external clear pin, the watchdog, or a pin-change wake. The block records the cause as three flag bits in an 8-bit status register. Those bits are: a pin-wake flag in bit 7, a power-down flag in bit 4 and a time-out flag in bit 3. Their values depend on the cause and on whether the device was sleeping when the event arrived.

The block keeps its own sleep flag. A one-cycle strobe sets it when the core executes its sleep instruction, and any restart or wake event clears it. On every restart the block also drives the restart values of three registers: the memory bank-select register, whose top two bits always read 1, and two 6-bit port direction registers, which return to all-input. A simple software write port updates the writable status bits, the bank-select field and the direction registers. A restart event in the same cycle overrides any software write.

All state is registered. The synchronous active-high `rst` input is the power-on restart.

Top module: `rcf_reset_cause`

## Requirements
- R1: While `rst` is high, on the next edge the status register becomes 0x18 (bits 7..3 = 0,0,0,1,1 and bits 2..0 = 0). In the same update, bank-select becomes 0xC0, both direction registers become 0x3F and the sleep flag clears.
- R2: An external clear while awake clears status bits 7, 6 and 5 and leaves bits 4, 3 and 2..0 unchanged.
- R3: An external clear while asleep sets status bits 7..3 to 0,0,0,1,0 and leaves bits 2..0 unchanged.
- R4: A watchdog time-out while awake sets status bits 7..3 to 0,0,0,0,1 and leaves bits 2..0 unchanged.
- R5: A watchdog time-out while asleep sets status bits 7..3 to all zero and leaves bits 2..0 unchanged.
- R6: A pin-change wake while asleep sets status bits 7..3 to 1,0,0,1,0. A pin-change wake while awake has no effect on any register.
- R7: Every external clear, watchdog time-out or effective pin wake resets both direction registers to 0x3F. It leaves bank-select bits 5..0 unchanged. Bank-select bits 7..6 always read 1.
- R8: Simultaneous events resolve by priority: `rst` first, then external clear, then watchdog, then pin wake.
- R9: `sleep_enter_i` sets the sleep flag (`asleep_o`). Any restart or effective wake event clears it, including one in the same cycle as the strobe.
- R10: A status write with `st_we_i` updates bits 5 and 2..0 from `wdata_i`. Bits 7, 4 and 3 are unaffected and bit 6 reads 0. A restart event in the same cycle overrides the write.
- R11: `bank_we_i` writes bank-select bits 5..0. `dir_we_i[n]` writes direction register n (port 0 in `dir_o[5:0]`, port 1 in `dir_o[11:6]`). A restart event in the same cycle overrides these writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous power-on restart, active high |
| ext_clr_i | input | 1 | External clear event |
| wdt_to_i | input | 1 | Watchdog time-out event |
| pin_wake_i | input | 1 | Pin-change wake event |
| sleep_enter_i | input | 1 | One-cycle strobe on entering sleep |
| st_we_i | input | 1 | Status write enable |
| bank_we_i | input | 1 | Bank-select write enable |
| dir_we_i | input | NUM_PORTS | Direction register write enables |
| wdata_i | input | 8 | Software write data |
| status_o | output | 8 | Status register |
| bank_o | output | 8 | Bank-select register |
| dir_o | output | NUM_PORTS*DIR_W | Direction registers, port 0 in the low bits |
| asleep_o | output | 1 | Sleep flag |

## Verification
Two kinds of activity can land in the same cycle. The first is a restart or wake event together with a software write or a sleep strobe. The second is several restart causes at once. The bench provokes the first by raising a watchdog or external clear together with a status, direction or bank write, or with the sleep strobe. It then checks that the event's flag pattern and the all-input directions win and that the sleep flag ends clear. For the second, it raises external clear, watchdog and pin wake together while asleep, and later raises `rst` together with external clear. It judges both by the flag pattern of the highest-priority cause alone.

// File: rtl/rcf_pkg.sv
package rcf_pkg;
  localparam int ST_W     = 8;
  localparam int PCW_BIT  = 7;
  localparam int PAGE_BIT = 5;
  localparam int PDN_BIT  = 4;
  localparam int TON_BIT  = 3;
  localparam int LOW_W    = 3;
  localparam logic [ST_W-1:0] ST_POR = 8'h18;

  typedef enum logic [1:0] {
    CZ_NONE = 2'd0,
    CZ_EXT  = 2'd1,
    CZ_WDT  = 2'd2,
    CZ_PIN  = 2'd3
  } cause_e;

  typedef struct packed {
    logic pcw;
    logic pdn;
    logic ton;
  } flags_t;
endpackage

// File: rtl/rcf_cause_arb.sv
module rcf_cause_arb
  import rcf_pkg::*;
(
  input  logic   ext_clr,
  input  logic   wdt_to,
  input  logic   pin_wake,
  input  logic   asleep,
  output cause_e cause
);
  // fixed priority: external clear, watchdog, then pin wake (only while asleep)
  always_comb begin
    if (ext_clr)                cause = CZ_EXT;
    else if (wdt_to)            cause = CZ_WDT;
    else if (pin_wake && asleep) cause = CZ_PIN;
    else                        cause = CZ_NONE;
  end
endmodule

// File: rtl/rcf_flag_table.sv
module rcf_flag_table
  import rcf_pkg::*;
(
  input  cause_e cause,
  input  logic   asleep,
  input  flags_t cur,
  output flags_t nxt
);
  always_comb begin
    nxt = cur;
    unique case (cause)
      CZ_EXT: begin
        nxt.pcw = 1'b0;
        if (asleep) begin
          nxt.pdn = 1'b1;
          nxt.ton = 1'b0;
        end
      end
      CZ_WDT: begin
        nxt.pcw = 1'b0;
        nxt.pdn = 1'b0;
        nxt.ton = !asleep;
      end
      CZ_PIN: begin
        nxt.pcw = 1'b1;
        nxt.pdn = 1'b1;
        nxt.ton = 1'b0;
      end
      default: nxt = cur;
    endcase
  end
endmodule

// File: rtl/rcf_dir_reg.sv
module rcf_dir_reg #(
  parameter int DIR_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt,
  input  logic             we,
  input  logic [DIR_W-1:0] wd,
  output logic [DIR_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || evt) q <= '1;
    else if (we)    q <= wd;
  end

  a_r7_dir_all_input: assert property (@(posedge clk) disable iff (rst)
    evt |=> q == {DIR_W{1'b1}});
  a_r11_dir_write: assert property (@(posedge clk) disable iff (rst)
    (we && !evt) |=> q == $past(wd));
endmodule

// File: rtl/rcf_reset_cause.sv
module rcf_reset_cause
  import rcf_pkg::*;
#(
  parameter int DIR_W     = 6,
  parameter int NUM_PORTS = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       ext_clr_i,
  input  logic                       wdt_to_i,
  input  logic                       pin_wake_i,
  input  logic                       sleep_enter_i,
  input  logic                       st_we_i,
  input  logic                       bank_we_i,
  input  logic [NUM_PORTS-1:0]       dir_we_i,
  input  logic [7:0]                 wdata_i,
  output logic [7:0]                 status_o,
  output logic [7:0]                 bank_o,
  output logic [NUM_PORTS*DIR_W-1:0] dir_o,
  output logic                       asleep_o
);
  localparam int BANK_FIX = 2;
  localparam int BANK_LO  = 8 - BANK_FIX;

  cause_e             cause;
  flags_t             cur_f, nxt_f;
  logic               evt;
  logic               asleep_q;
  logic               page_q;
  logic [LOW_W-1:0]   low_q;
  logic [BANK_LO-1:0] bank_q;

  rcf_cause_arb u_arb (
    .ext_clr (ext_clr_i),
    .wdt_to  (wdt_to_i),
    .pin_wake(pin_wake_i),
    .asleep  (asleep_q),
    .cause   (cause)
  );

  rcf_flag_table u_tbl (
    .cause (cause),
    .asleep(asleep_q),
    .cur   (cur_f),
    .nxt   (nxt_f)
  );

  assign evt = (cause != CZ_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_f    <= '{pcw: 1'b0, pdn: 1'b1, ton: 1'b1};
      page_q   <= 1'b0;
      low_q    <= '0;
      asleep_q <= 1'b0;
      bank_q   <= '0;
    end else if (evt) begin
      cur_f    <= nxt_f;
      page_q   <= 1'b0;
      asleep_q <= 1'b0;
    end else begin
      if (sleep_enter_i) asleep_q <= 1'b1;
      if (st_we_i) begin
        page_q <= wdata_i[PAGE_BIT];
        low_q  <= wdata_i[LOW_W-1:0];
      end
      if (bank_we_i) bank_q <= wdata_i[BANK_LO-1:0];
    end
  end

  generate
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_dir
      rcf_dir_reg #(.DIR_W(DIR_W)) u_dir (
        .clk(clk),
        .rst(rst),
        .evt(evt),
        .we (dir_we_i[p]),
        .wd (wdata_i[DIR_W-1:0]),
        .q  (dir_o[p*DIR_W +: DIR_W])
      );
    end
  endgenerate

  assign status_o = {cur_f.pcw, 1'b0, page_q, cur_f.pdn, cur_f.ton, low_q};
  assign bank_o   = {{BANK_FIX{1'b1}}, bank_q};
  assign asleep_o = asleep_q;

  a_r2_ext_awake_keeps: assert property (@(posedge clk) disable iff (rst)
    (ext_clr_i && !asleep_o) |=>
      (status_o[4:3] == $past(status_o[4:3])) && (status_o[7:5] == 3'b000));
  a_r3_ext_asleep: assert property (@(posedge clk) disable iff (rst)
    (ext_clr_i && asleep_o) |=> status_o[7:3] == 5'b00010);
  a_r4_wdt_awake: assert property (@(posedge clk) disable iff (rst)
    (wdt_to_i && !ext_clr_i && !asleep_o) |=> status_o[7:3] == 5'b00001);
  a_r5_wdt_asleep: assert property (@(posedge clk) disable iff (rst)
    (wdt_to_i && !ext_clr_i && asleep_o) |=> status_o[7:3] == 5'b00000);
  a_r6_pin_wake: assert property (@(posedge clk) disable iff (rst)
    (pin_wake_i && asleep_o && !ext_clr_i && !wdt_to_i) |=> status_o[7:3] == 5'b10010);
  a_r6_pin_ignored: assert property (@(posedge clk) disable iff (rst)
    (pin_wake_i && !asleep_o && !ext_clr_i && !wdt_to_i && !st_we_i) |=> $stable(status_o));
  a_r9_sleep_cleared: assert property (@(posedge clk) disable iff (rst)
    (ext_clr_i || wdt_to_i || (pin_wake_i && asleep_o)) |=> !asleep_o);
  a_r10_ro_bits: assert property (@(posedge clk) disable iff (rst)
    (st_we_i && !ext_clr_i && !wdt_to_i && !(pin_wake_i && asleep_o)) |=>
      (status_o[7] == $past(status_o[7])) && (status_o[4:3] == $past(status_o[4:3])));
  a_r7_bank_low_kept: assert property (@(posedge clk) disable iff (rst)
    (ext_clr_i || wdt_to_i) |=> bank_o == $past(bank_o));
endmodule

// File: tb/rcf_reset_cause_tb_top.sv
module rcf_reset_cause_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ext_clr_i = 0, wdt_to_i = 0, pin_wake_i = 0, sleep_enter_i = 0;
  logic        st_we_i = 0, bank_we_i = 0;
  logic [1:0]  dir_we_i = '0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  status_o, bank_o;
  logic [11:0] dir_o;
  logic        asleep_o;
  int          n_chk = 0, n_bad = 0, cyc = 0;

  always #2 clk = ~clk;

  rcf_reset_cause dut_i (
    .clk(clk), .rst(rst), .ext_clr_i(ext_clr_i), .wdt_to_i(wdt_to_i),
    .pin_wake_i(pin_wake_i), .sleep_enter_i(sleep_enter_i), .st_we_i(st_we_i),
    .bank_we_i(bank_we_i), .dir_we_i(dir_we_i), .wdata_i(wdata_i),
    .status_o(status_o), .bank_o(bank_o), .dir_o(dir_o), .asleep_o(asleep_o)
  );

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive one cycle of stimulus at a falling edge, then clear it one cycle later
  task automatic step(input logic r, input logic e, input logic w, input logic p,
                      input logic s, input logic sw, input logic bw,
                      input logic [1:0] dw, input logic [7:0] d);
    @(negedge clk);
    rst = r; ext_clr_i = e; wdt_to_i = w; pin_wake_i = p; sleep_enter_i = s;
    st_we_i = sw; bank_we_i = bw; dir_we_i = dw; wdata_i = d;
    @(negedge clk);
    rst = 0; ext_clr_i = 0; wdt_to_i = 0; pin_wake_i = 0; sleep_enter_i = 0;
    st_we_i = 0; bank_we_i = 0; dir_we_i = '0; wdata_i = '0;
  endtask

  task automatic t_por();
    step(1, 0, 0, 0, 0, 0, 0, 2'b00, 8'h00);
    chk("R1 status", {4'h0, status_o}, 12'h018);
    chk("R1 bank", {4'h0, bank_o}, 12'h0C0);
    chk("R1 dir", dir_o, 12'hFFF);
    chk("R1 asleep", {11'h0, asleep_o}, 12'h000);
  endtask

  task automatic t_sw_write();
    step(0, 0, 0, 0, 0, 1, 0, 2'b00, 8'hFF);
    chk("R10 write ff", {4'h0, status_o}, 12'h03F);
    step(0, 0, 0, 0, 0, 1, 0, 2'b00, 8'h02);
    chk("R10 write 02", {4'h0, status_o}, 12'h01A);
    step(0, 0, 0, 0, 0, 0, 1, 2'b00, 8'h2A);
    chk("R11 bank", {4'h0, bank_o}, 12'h0EA);
    step(0, 0, 0, 0, 0, 0, 0, 2'b01, 8'h15);
    step(0, 0, 0, 0, 0, 0, 0, 2'b10, 8'h2A);
    chk("R11 dir", dir_o, {6'h2A, 6'h15});
  endtask

  task automatic t_wdt_awake();
    step(0, 0, 1, 0, 0, 0, 0, 2'b00, 8'h00);
    chk("R4 status", {4'h0, status_o}, 12'h00A);
    chk("R7 dir", dir_o, 12'hFFF);
    chk("R7 bank", {4'h0, bank_o}, 12'h0EA);
  endtask

  task automatic t_ext_awake();
    step(0, 0, 0, 0, 0, 1, 0, 2'b00, 8'h25);
    chk("R10 setup", {4'h0, status_o}, 12'h02D);
    step(0, 1, 0, 0, 0, 0, 0, 2'b00, 8'h00);
    chk("R2 status", {4'h0, status_o}, 12'h00D);
  endtask

  task automatic t_ext_asleep();
    step(0, 0, 0, 0, 1, 0, 0, 2'b00, 8'h00);
    chk("R9 set", {11'h0, asleep_o}, 12'h001);
    step(0, 1, 0, 0, 0, 0, 0, 2'b00, 8'h00);
    chk("R3 status", {4'h0, status_o}, 12'h015);
    chk("R9 clear", {11'h0, asleep_o}, 12'h000);
  endtask

  task automatic t_wdt_asleep();
    step(0, 0, 0, 0, 1, 0, 0, 2'b00, 8'h00);
    step(0, 0, 1, 0, 0, 0, 0, 2'b00, 8'h00);
    chk("R5 status", {4'h0, status_o}, 12'h005);
  endtask

  task automatic t_pin();
    step(0, 0, 0, 0, 0, 0, 0, 2'b01, 8'h01);
    step(0, 0, 0, 1, 0, 0, 0, 2'b00, 8'h00);
    chk("R6 ignored status", {4'h0, status_o}, 12'h005);
    chk("R6 ignored dir", dir_o, 12'hFC1);
    step(0, 0, 0, 0, 1, 0, 0, 2'b00, 8'h00);
    step(0, 0, 0, 1, 0, 0, 0, 2'b00, 8'h00);
    chk("R6 wake status", {4'h0, status_o}, 12'h095);
    chk("R6 wake dir", dir_o, 12'hFFF);
    chk("R9 wake clears", {11'h0, asleep_o}, 12'h000);
    step(0, 0, 0, 0, 0, 1, 0, 2'b00, 8'h00);
    chk("R10 ro bits", {4'h0, status_o}, 12'h090);
  endtask

  task automatic t_priority();
    step(0, 0, 0, 0, 0, 1, 0, 2'b00, 8'h05);
    step(0, 0, 0, 0, 1, 0, 0, 2'b00, 8'h00);
    step(0, 1, 1, 1, 0, 0, 0, 2'b00, 8'h00);
    chk("R8 ext first", {4'h0, status_o}, 12'h015);
    step(0, 0, 0, 0, 1, 0, 0, 2'b00, 8'h00);
    step(0, 0, 1, 1, 0, 0, 0, 2'b00, 8'h00);
    chk("R8 wdt over pin", {4'h0, status_o}, 12'h005);
    step(0, 0, 1, 0, 1, 0, 0, 2'b00, 8'h00);
    chk("R9 event beats strobe", {11'h0, asleep_o}, 12'h000);
    chk("R4 with strobe", {4'h0, status_o}, 12'h00D);
  endtask

  task automatic t_collide();
    step(0, 0, 1, 0, 0, 1, 0, 2'b00, 8'hFF);
    chk("R10 event beats write", {4'h0, status_o}, 12'h00D);
    step(0, 1, 0, 0, 0, 0, 1, 2'b10, 8'h00);
    chk("R11 dir event wins", dir_o, 12'hFFF);
    chk("R11 bank event wins", {4'h0, bank_o}, 12'h0EA);
    step(1, 1, 0, 0, 0, 0, 0, 2'b00, 8'h00);
    chk("R8 rst first", {4'h0, status_o}, 12'h018);
    chk("R1 bank again", {4'h0, bank_o}, 12'h0C0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_por();
    t_sw_write();
    t_wdt_awake();
    t_ext_awake();
    t_ext_asleep();
    t_wdt_asleep();
    t_pin();
    t_priority();
    t_collide();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule